// File: doc/BRIEF.md
# Instruction Prefix Context Propagator

This block lets one instruction prefix be recorded once and then applied to many of the following 32-bit suffix instructions. It holds seven context slots. Each slot pairs a stored 32-bit context with a 40-bit schedule. The schedule is a bit-level FIFO built as a shift register. For the current suffix instruction, a slot's context takes part only when bit 0 of that slot's schedule is set. All the slots that take part are combined by a bitwise OR into one merged prefix. No priority is applied between slots.

A load operation names a slot with a 3-bit code. Codes 1 to 7 select the slots and code 0 means "no slot". The load copies a 24-bit prefix field into the selected slot and a 21-bit schedule into that slot's FIFO. An advance strobe fires once per issued suffix instruction and moves every schedule on by one instruction. A 64-bit word port reads and writes the whole packed state, so that an operating system can save it and later restore it.

Top module: `ctxprop_top`

## Requirements
- R1: After reset every context and every schedule is zero: mergedValid is 0, mergedCtx is 0, and every one of the eight 64-bit words reads 0.
- R2: A load whose slot code is 0 changes no state. No word changes and the merged output is unchanged.
- R3: A load to slot code n (1 to 7) stores {8'h00, prefix[23:0]} as context n. It also stores the 21-bit schedule in bits 20:0 of FIFO n and clears bits 39:21 of that FIFO.
- R4: mergedCtx is the bitwise OR of the contexts of all slots whose FIFO bit 0 is 1, and it is 0 when no such slot exists. mergedValid is 1 exactly when at least one FIFO bit 0 is 1. Both outputs follow the state with no extra cycle.
- R5: On each advance every FIFO shifts right by one bit and a 0 enters bit 39. A schedule bit loaded at position k therefore reaches bit 0 after k advances and leaves after k+1 advances.
- R6: When a load and an advance fall in the same cycle, all FIFOs shift first. The loaded slot then takes the unshifted new schedule, so schedule bit 0 applies to the next instruction.
- R7: The state is packed LSB-first into a 504-bit vector. Context n occupies bits 32(n-1) to 32(n-1)+31. FIFO n occupies bits 224+40(n-1) to 224+40(n-1)+39. Word w (regAddr) is vector bits 64w to 64w+63. regRdData is combinational from regAddr.
- R8: A word write replaces word regAddr with regWrData at the clock edge. It takes effect after any advance and load of the same cycle, and the other words keep the results of those operations.
- R9: Vector bits 504 to 511, which are the top byte of word 7, always read 0, and writes to them are dropped.
- R10: In a cycle with no advance, no load and no write, the state and both merged outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| advance | input | 1 | One pulse per issued suffix instruction |
| loadEn | input | 1 | Load strobe |
| loadSlot | input | 3 | Slot code; 0 = no slot |
| loadPrefix | input | 24 | Prefix field to store |
| loadSched | input | 21 | Schedule for the following instructions |
| regAddr | input | 3 | Word index for read and write |
| regWrEn | input | 1 | Word write strobe |
| regWrData | input | 64 | Word write data |
| regRdData | output | 64 | Word read data |
| mergedCtx | output | 32 | OR-merged active contexts |
| mergedValid | output | 1 | At least one slot active |

## Verification
The assertions check four things on every cycle:
- mergedCtx is zero whenever mergedValid is low.
- A load with schedule bit 0 set shows its prefix in the merged output in the next cycle.
- A context word that was written reads back unchanged.
- An idle cycle leaves the merged output and the top byte of word 7 unchanged.

Only the bench scenarios can show the exact bit positions of the packing and the OR of several overlapping contexts. They also cover the timing of a far schedule bit across twenty advances, and the ordering when a load, an advance and a write fall in the same cycle. Those scenarios compare every word against a reference model after each step.

// File: rtl/ctxprop_pkg.sv
package ctxprop_pkg;
  parameter int NUM_SLOTS = 7;
  parameter int CTX_W     = 32;
  parameter int FIFO_W    = 40;
  parameter int PREFIX_W  = 24;
  parameter int SCHED_W   = 21;
  parameter int REG_W     = 64;

  localparam int SLOT_W    = $clog2(NUM_SLOTS + 1);
  localparam int FIFO_BASE = NUM_SLOTS * CTX_W;
  localparam int FLAT_W    = NUM_SLOTS * (CTX_W + FIFO_W);
  localparam int NUM_REGS  = (FLAT_W + REG_W - 1) / REG_W;
  localparam int STORE_W   = NUM_REGS * REG_W;
  localparam int ADDR_W    = $clog2(NUM_REGS);

  typedef struct packed {
    logic              shiftAll;
    logic              loadSlot;
    logic [SLOT_W-1:0] loadIdx;
    logic              wordWrite;
  } ctrlStrobes_t;
endpackage

// File: rtl/ctxprop_ctrl.sv
module ctxprop_ctrl
  import ctxprop_pkg::*;
(
  input  logic              advance,
  input  logic              loadEn,
  input  logic [SLOT_W-1:0] loadSlot,
  input  logic              regWrEn,
  output ctrlStrobes_t      strobes
);
  logic slotNamed;

  always_comb begin
    slotNamed         = (loadSlot != '0);
    strobes.shiftAll  = advance;
    strobes.loadSlot  = loadEn && slotNamed;
    strobes.loadIdx   = slotNamed ? loadSlot - SLOT_W'(1) : '0;
    strobes.wordWrite = regWrEn;
  end
endmodule

// File: rtl/ctxprop_datapath.sv
module ctxprop_datapath
  import ctxprop_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobes_t        strobes,
  input  logic [PREFIX_W-1:0] loadPrefix,
  input  logic [SCHED_W-1:0]  loadSched,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  output logic [CTX_W-1:0]    mergedCtx,
  output logic                mergedValid
);
  localparam int PAD_W = STORE_W - FLAT_W;

  logic [FLAT_W-1:0]  stateQ;
  logic [FLAT_W-1:0]  stateD;
  logic [STORE_W-1:0] viewQ;
  logic [STORE_W-1:0] viewD;
  logic [NUM_SLOTS-1:0] activeLsb;
  logic [CTX_W-1:0]     gated [NUM_SLOTS];

  // Per-slot gating of contexts by schedule LSB
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign activeLsb[s] = stateQ[FIFO_BASE + s*FIFO_W];
    assign gated[s]     = activeLsb[s] ? stateQ[s*CTX_W +: CTX_W] : '0;
  end

  always_comb begin
    mergedCtx = '0;
    for (int s = 0; s < NUM_SLOTS; s++) mergedCtx |= gated[s];
    mergedValid = |activeLsb;
  end

  assign viewQ     = {{PAD_W{1'b0}}, stateQ};
  assign regRdData = viewQ[int'(regAddr)*REG_W +: REG_W];

  // Next state: shift, then load, then word overwrite
  always_comb begin
    logic [FLAT_W-1:0] work;
    work = stateQ;
    if (strobes.shiftAll) begin
      for (int s = 0; s < NUM_SLOTS; s++)
        work[FIFO_BASE + s*FIFO_W +: FIFO_W] = stateQ[FIFO_BASE + s*FIFO_W +: FIFO_W] >> 1;
    end
    if (strobes.loadSlot) begin
      work[int'(strobes.loadIdx)*CTX_W +: CTX_W] =
        {{(CTX_W-PREFIX_W){1'b0}}, loadPrefix};
      work[FIFO_BASE + int'(strobes.loadIdx)*FIFO_W +: FIFO_W] =
        {{(FIFO_W-SCHED_W){1'b0}}, loadSched};
    end
    viewD = {{PAD_W{1'b0}}, work};
    if (strobes.wordWrite)
      viewD[int'(regAddr)*REG_W +: REG_W] = regWrData;
    stateD = viewD[FLAT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= '0;
    else     stateQ <= stateD;
  end
endmodule

// File: rtl/ctxprop_top.sv
module ctxprop_top
  import ctxprop_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                advance,
  input  logic                loadEn,
  input  logic [SLOT_W-1:0]   loadSlot,
  input  logic [PREFIX_W-1:0] loadPrefix,
  input  logic [SCHED_W-1:0]  loadSched,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  output logic [CTX_W-1:0]    mergedCtx,
  output logic                mergedValid
);
  ctrlStrobes_t strobes;

  ctxprop_ctrl u_ctrl (
    .advance (advance),
    .loadEn  (loadEn),
    .loadSlot(loadSlot),
    .regWrEn (regWrEn),
    .strobes (strobes)
  );

  ctxprop_datapath u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .loadPrefix (loadPrefix),
    .loadSched  (loadSched),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .mergedCtx  (mergedCtx),
    .mergedValid(mergedValid)
  );
endmodule

// File: rtl/ctxprop_chk.sv
module ctxprop_chk
  import ctxprop_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                advance,
  input logic                loadEn,
  input logic [SLOT_W-1:0]   loadSlot,
  input logic [PREFIX_W-1:0] loadPrefix,
  input logic [SCHED_W-1:0]  loadSched,
  input logic [ADDR_W-1:0]   regAddr,
  input logic                regWrEn,
  input logic [REG_W-1:0]    regWrData,
  input logic [REG_W-1:0]    regRdData,
  input logic [CTX_W-1:0]    mergedCtx,
  input logic                mergedValid
);
  localparam int CTX_WORDS = (NUM_SLOTS * CTX_W) / REG_W;

  a_r4_zero_when_idle: assert property (@(posedge clk) disable iff (rst)
    !mergedValid |-> (mergedCtx == '0));

  a_r3_load_visible: assert property (@(posedge clk) disable iff (rst)
    (loadEn && loadSlot != '0 && loadSched[0] && !regWrEn)
    |=> mergedValid &&
        ((mergedCtx[PREFIX_W-1:0] & $past(loadPrefix)) == $past(loadPrefix)));

  a_r8_word_readback: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && int'(regAddr) < CTX_WORDS)
    |=> (regAddr != $past(regAddr)) || (regRdData == $past(regWrData)));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!advance && !loadEn && !regWrEn) |=> $stable(mergedCtx) && $stable(mergedValid));

  a_r9_pad_zero: assert property (@(posedge clk) disable iff (rst)
    (int'(regAddr) == NUM_REGS - 1) |-> (regRdData[REG_W-1:REG_W-8] == 8'h00));
endmodule

bind ctxprop_top ctxprop_chk u_chk (
  .clk(clk), .rst(rst), .advance(advance), .loadEn(loadEn), .loadSlot(loadSlot),
  .loadPrefix(loadPrefix), .loadSched(loadSched), .regAddr(regAddr),
  .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
  .mergedCtx(mergedCtx), .mergedValid(mergedValid)
);

// File: tb/ctxprop_top_tb.sv
module ctxprop_top_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        advance, loadEn, regWrEn;
  logic [2:0]  loadSlot, regAddr;
  logic [23:0] loadPrefix;
  logic [20:0] loadSched;
  logic [63:0] regWrData, regRdData;
  logic [31:0] mergedCtx;
  logic        mergedValid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] mCtx  [7];
  logic [39:0] mFifo [7];

  always #5 clk = ~clk;

  ctxprop_top u_dut (
    .clk(clk), .rst(rst), .advance(advance), .loadEn(loadEn), .loadSlot(loadSlot),
    .loadPrefix(loadPrefix), .loadSched(loadSched), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .mergedCtx(mergedCtx), .mergedValid(mergedValid)
  );

  function automatic logic [63:0] wordOf(int w);
    logic [63:0] r;
    for (int b = 0; b < 64; b++) begin
      int idx = w*64 + b;
      if (idx < 224)      r[b] = mCtx[idx/32][idx%32];
      else if (idx < 504) r[b] = mFifo[(idx-224)/40][(idx-224)%40];
      else                r[b] = 1'b0;
    end
    return r;
  endfunction

  function automatic void writeWord(int w, logic [63:0] d);
    for (int b = 0; b < 64; b++) begin
      int idx = w*64 + b;
      if (idx < 224)      mCtx[idx/32][idx%32] = d[b];
      else if (idx < 504) mFifo[(idx-224)/40][(idx-224)%40] = d[b];
    end
  endfunction

  function automatic logic [31:0] expMerged();
    logic [31:0] m = '0;
    for (int s = 0; s < 7; s++) if (mFifo[s][0]) m |= mCtx[s];
    return m;
  endfunction

  function automatic logic expValid();
    logic v = 1'b0;
    for (int s = 0; s < 7; s++) v |= mFifo[s][0];
    return v;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic checkMerged(string tag);
    check(tag, {32'h0, mergedCtx}, {32'h0, expMerged()}, "mergedCtx");
    check(tag, {63'h0, mergedValid}, {63'h0, expValid()}, "mergedValid");
  endtask

  task automatic sweep(string tag);
    for (int w = 0; w < 8; w++) begin
      regAddr = w[2:0];
      #1 check(tag, regRdData, wordOf(w), $sformatf("word %0d", w));
    end
  endtask

  task automatic step(bit adv, bit ld, int slot, logic [23:0] pre, logic [20:0] sch,
                      bit wr, int addr, logic [63:0] data, string tag);
    advance = adv; loadEn = ld; loadSlot = slot[2:0]; loadPrefix = pre;
    loadSched = sch; regWrEn = wr; regAddr = addr[2:0]; regWrData = data;
    @(posedge clk);
    if (adv) for (int s = 0; s < 7; s++) mFifo[s] = mFifo[s] >> 1;
    if (ld && slot != 0) begin
      mCtx[slot-1]  = {8'h00, pre};
      mFifo[slot-1] = {19'h0, sch};
    end
    if (wr) writeWord(addr, data);
    @(negedge clk);
    advance = 0; loadEn = 0; regWrEn = 0;
    #1 checkMerged(tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int s = 0; s < 7; s++) begin mCtx[s] = '0; mFifo[s] = '0; end
    rst = 1; advance = 0; loadEn = 0; loadSlot = 0; loadPrefix = 0; loadSched = 0;
    regWrEn = 0; regAddr = 0; regWrData = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1 checkMerged("R1"); sweep("R1");

    // R2: slot code 0 ignored
    step(0, 1, 0, 24'hFFFFFF, 21'h1FFFFF, 0, 0, 0, "R2"); sweep("R2");
    // R3: load stored zero-extended, schedule low bits
    step(0, 1, 3, 24'hABCDEF, 21'b101, 0, 0, 0, "R3"); sweep("R3");
    // R4: OR merge of two active slots
    step(0, 1, 5, 24'h0F0F00, 21'b1, 0, 0, 0, "R4");
    check("R4", {32'h0, mergedCtx}, {32'h0, 32'h00AFCFEF}, "merged literal");
    // R5: shift right
    step(1, 0, 0, 0, 0, 0, 0, 0, "R5");
    check("R5", {63'h0, mergedValid}, 64'h0, "valid after one advance");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R5");
    check("R5", {32'h0, mergedCtx}, {32'h0, 32'h00ABCDEF}, "slot3 second bit");
    // R6: load with advance same cycle
    step(1, 1, 2, 24'h000123, 21'b1, 0, 0, 0, "R6");
    check("R6", {63'h0, mergedValid}, 64'h1, "new schedule bit0 live");
    // R5: far bit 20
    step(0, 1, 7, 24'h800000, 21'h100000, 0, 0, 0, "R5");
    for (int i = 0; i < 20; i++) step(1, 0, 0, 0, 0, 0, 0, 0, "R5");
    check("R5", {32'h0, mergedCtx}, {32'h0, 32'h00800000}, "bit20 after 20 advances");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R5");
    check("R5", {63'h0, mergedValid}, 64'h0, "bit20 gone after 21");
    // R10: idle hold
    step(0, 1, 1, 24'h00BEEF, 21'h3, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R10"); sweep("R10");
    // R9: pad byte
    step(0, 0, 0, 0, 0, 1, 7, 64'hFFFF_FFFF_FFFF_FFFF, "R9"); sweep("R9");
    // R8: write with advance and load in same cycle
    step(1, 1, 4, 24'h555555, 21'h7, 1, 3, 64'h0000_0003_1234_5678, "R8"); sweep("R8");
    step(0, 0, 0, 0, 0, 1, 0, 64'hCAFE_0000_0000_F00D, "R8"); sweep("R7");

    // Random phase
    for (int i = 0; i < 400; i++) begin
      bit adv = ($urandom % 3) != 0;
      bit ld  = ($urandom % 3) == 0;
      bit wr  = ($urandom % 9) == 0;
      step(adv, ld, $urandom % 8, 24'($urandom), 21'($urandom),
           wr, $urandom % 8, {$urandom, $urandom}, "R4");
      if (i % 4 == 0) sweep("R7");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule